// File: doc/BRIEF.md
# Strobe-Kicked Watchdog Timer

This block measures the time since the host last serviced it and asks the reset sequencer for a system reset when that time grows too long. Time is counted in millisecond ticks, which arrive as a one-clock enable on `ms_tick`. The host services the watchdog by driving `strobe_in` from high to low. Only that falling transition counts as service: a line held high, held low, or rising does nothing. There is no enable, so the block always runs while the system is out of reset.

`period_sel` picks one of three timeout lengths, 150, 610 or 1200 ticks by default. While the reset sequencer reports `sys_rst_active`, the count is held at zero, strobes are ignored and no request is raised. Counting starts again from zero once that input drops. A timeout appears as a single-clock pulse on `timeout_req`, and the count then starts over. The strobe is asynchronous to `clk`, so it passes through a two-flop synchroniser before its falling edge is detected. The interface uses only plain control pins. There is no data stream, so no valid/ready handshake applies.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, `timeout_req` is low and the count is zero. After release, a full period must pass before any request.
- R2: `period_sel` encodes the period as 2'b00 = P_SHORT_MS ticks, 2'b01 = P_MID_MS ticks and 2'b10 = P_LONG_MS ticks. The defaults are 150, 610 and 1200. The value is sampled on every tick.
- R3: `period_sel` = 2'b11 behaves exactly like 2'b10.
- R4: Suppose no valid strobe edge and no `sys_rst_active` occur after a restart. The clock edge that samples the N-th `ms_tick` since that restart, where N is the selected period, sets `timeout_req` high for the following cycle. A request only ever follows an edge at which `ms_tick` was high.
- R5: `timeout_req` is high for exactly one clock. The count restarts from zero on the same edge.
- R6: Only a high-to-low change of `strobe_in` restarts the count. A steady high level, a steady low level or a rising change has no effect on when the next request comes.
- R7: `strobe_in` passes through two synchronising flops. A falling edge clears the count on the third rising clock edge after the new low level is first sampled, whether or not a tick is present on that edge. A low pulse one clock wide is enough.
- R8: While `sys_rst_active` is high, the count is held at zero, strobe edges are discarded and `timeout_req` stays low. After it drops, counting resumes from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-clock millisecond enable |
| strobe_in | input | 1 | Host service line (asynchronous), falling edge kicks |
| period_sel | input | 2 | Timeout length select |
| sys_rst_active | input | 1 | High while the reset sequencer holds the system in reset |
| timeout_req | output | 1 | One-clock request for a system reset |

## Verification
A count that is off by one, or a limit taken from the wrong select code, moves a `timeout_req` pulse by at least one tick period. The per-clock comparison catches this at the first expected timeout after a restart. A broken synchroniser or edge detector shows up in one of three ways. A steady low level might act as a kick, a kick might land a clock early or late, or a single-clock pulse might be lost, which produces an unwanted request one period later. A count that is not held during `sys_rst_active` fires early after release, within one period.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_ALT   = 2'b11
  } period_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/wd_strobe_sync.sv
module wd_strobe_sync #(
  parameter int  STAGES = 2,
  parameter bit  IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= IDLE;
          else        pipe_q[0] <= strobe_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= IDLE;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  // newest synchronised sample low, previous one high
  assign fall_o = pipe_q[DEPTH-1] & ~pipe_q[DEPTH-2];

endmodule

// File: rtl/wd_period_sel.sv
module wd_period_sel
  import wd_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int P_SHORT = 150,
  parameter int P_MID   = 610,
  parameter int P_LONG  = 1200
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o
);
  always_comb begin
    unique case (period_sel_e'(sel_i))
      SEL_SHORT: limit_o = CNT_W'(P_SHORT);
      SEL_MID:   limit_o = CNT_W'(P_MID);
      SEL_LONG:  limit_o = CNT_W'(P_LONG);
      default:   limit_o = CNT_W'(P_LONG);
    endcase
  end

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] next_w;

  assign next_w = {1'b0, cnt_o} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (hold_i || kick_i) begin
        cnt_o <= '0;
      end else if (tick_i) begin
        if (next_w >= {1'b0, limit_i}) begin
          cnt_o    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_o <= next_w[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int P_SHORT_MS  = 150,
  parameter int P_MID_MS    = 610,
  parameter int P_LONG_MS   = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       strobe_in,
  input  logic [1:0] period_sel,
  input  logic       sys_rst_active,
  output logic       timeout_req
);
  localparam int MAX_P = wd_pkg::max3(P_SHORT_MS, P_MID_MS, P_LONG_MS);
  localparam int CNT_W = $clog2(MAX_P + 1);

  logic             strobe_fall;
  logic             kick;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;

  wd_strobe_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE   (1'b1)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_in (strobe_in),
    .fall_o    (strobe_fall)
  );

  assign kick = strobe_fall & ~sys_rst_active;

  wd_period_sel #(
    .CNT_W   (CNT_W),
    .P_SHORT (P_SHORT_MS),
    .P_MID   (P_MID_MS),
    .P_LONG  (P_LONG_MS)
  ) u_sel (
    .sel_i   (period_sel),
    .limit_o (limit)
  );

  wd_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (ms_tick),
    .kick_i   (kick),
    .hold_i   (sys_rst_active),
    .limit_i  (limit),
    .expire_o (timeout_req),
    .cnt_o    (cnt_q)
  );

endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             sys_rst_active,
  input logic             timeout_req,
  input logic [CNT_W-1:0] cnt_q
);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |=> !timeout_req);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_active |=> (!timeout_req && cnt_q == '0));

  // R4
  tick_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |-> $past(ms_tick));

  // R8
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_active) |-> cnt_q == '0);

endmodule

bind strobe_watchdog wd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ms_tick        (ms_tick),
  .sys_rst_active (sys_rst_active),
  .timeout_req    (timeout_req),
  .cnt_q          (cnt_q)
);

// File: tb/sim_strobe_watchdog.sv
module sim_strobe_watchdog;
  localparam int PS = 4;
  localparam int PM = 7;
  localparam int PL = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       strobe_in = 1'b1;
  logic [1:0] period_sel = 2'b00;
  logic       sys_rst_active = 1'b0;
  logic       timeout_req;

  always #4 clk = ~clk;

  strobe_watchdog #(
    .P_SHORT_MS (PS),
    .P_MID_MS   (PM),
    .P_LONG_MS  (PL)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ms_tick        (ms_tick),
    .strobe_in      (strobe_in),
    .period_sel     (period_sel),
    .sys_rst_active (sys_rst_active),
    .timeout_req    (timeout_req)
  );

  int    vectors = 0;
  int    errs = 0;
  int    pulses = 0;
  string cur_req = "R1";
  int    tick_per = 0;
  int    tick_ph = 0;
  bit    done = 0;

  // behavioural reference
  int m_cnt;
  bit m_to;
  bit hist[$];

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'b00:   return PS;
      2'b01:   return PM;
      default: return PL;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_to  = 0;
      hist  = '{1, 1, 1};
    end else begin
      bit fall;
      fall = (hist[2] == 1) && (hist[1] == 0);
      m_to = 0;
      if (sys_rst_active) m_cnt = 0;
      else if (fall) m_cnt = 0;
      else if (ms_tick) begin
        if (m_cnt + 1 >= period_of(period_sel)) begin
          m_cnt = 0;
          m_to  = 1;
        end else m_cnt++;
      end
      hist.push_front(strobe_in);
      void'(hist.pop_back());
    end
  end

  // compare and tick drive, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (timeout_req !== m_to) begin
        errs++;
        $display("FAIL %s: timeout_req=%0b expected %0b at %0t", cur_req, timeout_req, m_to, $time);
      end
      if (m_to) pulses++;
    end
    if (tick_per == 0) ms_tick <= 1'b0;
    else begin
      tick_ph++;
      ms_tick <= (tick_ph % tick_per) == 0;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state, then a full period before any request
    cur_req = "R1";
    run(5);
    if (timeout_req !== 1'b0) begin
      errs++;
      $display("FAIL R1: timeout_req=%0b expected 0 in reset", timeout_req);
    end
    vectors++;
    rst_n = 1'b1;
    tick_per = 3;
    run(10);
    // R2/R4: each select code, free running
    cur_req = "R2";
    period_sel = 2'b00; run(60);
    period_sel = 2'b01; run(80);
    period_sel = 2'b10; run(120);
    // R3: code 11 matches code 10
    cur_req = "R3";
    period_sel = 2'b11; run(120);
    // R5: ticks every clock
    cur_req = "R5";
    period_sel = 2'b00; tick_per = 1; run(30);
    tick_per = 3;
    // R6: steady low, then rising and steady high
    cur_req = "R6";
    strobe_in = 1'b0; run(60);
    strobe_in = 1'b1; run(60);
    // R7: single-clock low pulses, faster than the period
    cur_req = "R7";
    for (int k = 0; k < 12; k++) begin
      strobe_in = 1'b0; run(1);
      strobe_in = 1'b1; run(6 + (k % 3));
    end
    tick_per = 4;
    for (int k = 0; k < 6; k++) begin
      strobe_in = 1'b0; run(1);
      strobe_in = 1'b1; run(9);
    end
    run(40);
    // R8: strobes ignored and count held while reset is active
    cur_req = "R8";
    tick_per = 3;
    run(7);
    sys_rst_active = 1'b1;
    for (int k = 0; k < 10; k++) begin
      strobe_in = k[0]; run(5);
    end
    strobe_in = 1'b1; run(2);
    sys_rst_active = 1'b0;
    run(70);
    // R4: mid-run select change and a mid-run async reset
    cur_req = "R4";
    period_sel = 2'b10; run(20);
    period_sel = 2'b00; run(40);
    cur_req = "R1";
    rst_n = 1'b0; run(3);
    rst_n = 1'b1; run(50);
    vectors++;
    if (pulses < 10) begin
      errs++;
      $display("FAIL R4: request pulses=%0d expected at least 10", pulses);
    end
    finish_run();
  end

endmodule